// File: doc/BRIEF.md
# Frequency Lock Detector with Hysteresis

This block decides whether a recovered-clock oscillator runs close enough to its target frequency for a phase loop to take over. It counts edges of the divided oscillator clock over a measurement window timed by the reference clock, compares the count with an expected value chosen by two select codes, and keeps a loss-of-lock flag. Lock is gained only when the error is within 500 ppm. Once locked, the block stays locked until the error exceeds 1000 ppm. The band between the two limits is the hysteresis. A second output hands loop control to the phase loop while locked and back to the frequency loop otherwise.

The window lasts `WIN_BASE` periods of a 19.44 MHz reference. The number of reference cycles is scaled by the reference select so that the window always lasts the same time. The expected count therefore depends only on the line rate and the oscillator divider, and every rate works with every reference frequency.

The oscillator count crosses into the reference domain as a Gray code, so any ratio between the two clocks is safe. A controller with three states drives the outputs:
- PRIME discards the first window after reset.
- HUNT is the frequency loop acquiring.
- LOCKED is the phase loop tracking.

The transitions are:
- PRIME to HUNT at the first window end.
- HUNT to LOCKED when a window ends within the acquire limit.
- LOCKED to HUNT when a window ends beyond the hold limit.
- HUNT or LOCKED to HUNT on a select change.

Top module: `freq_lock_det`

## Requirements
- R1: While reset is asserted and right after it, `lol` is 1 and `phase_sel` is 0 (state PRIME). The first window after reset never declares lock.
- R2: `phase_sel` is always the inverse of `lol`. The phase loop is selected exactly while locked.
- R3: Out of lock (HUNT), a window whose count differs from the expected count by at most floor(expected/2000) declares lock: `lol` falls one cycle after that window ends.
- R4: While locked, a window whose error is at most floor(expected/1000) keeps lock.
- R5: While locked, a window whose error exceeds floor(expected/1000) raises `lol` one cycle after the window ends. This applies to both a fast and a slow oscillator.
- R6: Out of lock, an error between the two limits, above floor(expected/2000) and at most floor(expected/1000), does not declare lock.
- R7: A window lasts `WIN_BASE << ref_sel` reference cycles. `ref_sel` values 0, 1, 2 and 3 stand for 19.44, 38.88, 77.76 and 155.52 MHz. `lol` changes only one cycle after a window end, or after a select change.
- R8: The expected count is round(WIN_BASE * rate / (19.44 MHz * OSC_DIV)). The rate is taken from `rate_sel[1:0]`: 0 = 2488.32 MHz, 1 = 1250 MHz, 2 = 622.08 MHz, 3 = 155.52 MHz. When `rate_sel[2]` is 1, the rate is multiplied by 15/14.
- R9: Any change of `rate_sel` or `ref_sel` forces `lol` to 1 within a few cycles and restarts the window.
- R10: Counting stays exact when the divided oscillator clock is faster than the reference clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock; times the window and clocks the state |
| clk_osc | input | 1 | Oscillator clock after the fixed divide by OSC_DIV |
| rst_n | input | 1 | Active-low asynchronous reset |
| rate_sel | input | 3 | Line-rate code; bit 2 selects the 15/14 wrapper rate |
| ref_sel | input | 2 | Reference-frequency code |
| lol | output | 1 | Loss of lock, 1 while out of lock |
| phase_sel | output | 1 | 1 hands control to the phase loop, 0 to the frequency loop |

## Verification
The oscillator is driven at exact rate, 400 ppm fast, about 800 ppm fast and 1200 ppm fast. These separate acquisition, holding inside the hysteresis band, refusing to acquire inside the band, and loss of lock. A 15/14 wrapper rate first runs with the oscillator still at the native frequency, which shows that the table tells the two rates apart, and then runs with a matching oscillator, which shows that it locks. A switch to a lower reference code with a doubled oscillator checks that lock comes after exactly the shorter window, and that the Gray transfer counts correctly when the oscillator is faster. A slow oscillator checks loss of lock in the other direction.

// File: rtl/flk_pkg.sv
package flk_pkg;

    typedef enum logic [1:0] {
        ST_PRIME  = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } lock_state_e;

    // expected divided-oscillator edges in one window (window = win_base / 19.44 MHz)
    function automatic longint unsigned flk_expected(input int unsigned code,
                                                     input int unsigned win_base,
                                                     input int unsigned osc_div);
        longint unsigned rate_khz;
        longint unsigned num;
        longint unsigned den;
        unique case (code % 4)
            0:       rate_khz = 64'd2488320;
            1:       rate_khz = 64'd1250000;
            2:       rate_khz = 64'd622080;
            default: rate_khz = 64'd155520;
        endcase
        num = longint'(win_base) * rate_khz * ((code >= 4) ? 64'd15 : 64'd14);
        den = 64'd19440 * longint'(osc_div) * 64'd14;
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/flk_osc_tally.sv
module flk_osc_tally #(
    parameter int unsigned CW = 24
) (
    input  logic          clk_osc,
    input  logic          clk_ref,
    input  logic          rst_n,
    output logic [CW-1:0] cnt_ref
);
    logic [CW-1:0] bin_q;
    logic [CW-1:0] bin_nx;
    logic [CW-1:0] gray_q;
    logic [CW-1:0] sync1_q;
    logic [CW-1:0] sync2_q;
    logic [CW-1:0] bin_dec;

    assign bin_nx = bin_q + 1'b1;

    // oscillator domain: binary counter with registered Gray copy
    always_ff @(posedge clk_osc or negedge rst_n) begin
        if (!rst_n) begin
            bin_q  <= '0;
            gray_q <= '0;
        end else begin
            bin_q  <= bin_nx;
            gray_q <= bin_nx ^ (bin_nx >> 1);
        end
    end

    // reference domain: two-stage synchronizer on the Gray word
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            cnt_ref <= '0;
        end else begin
            sync1_q <= gray_q;
            sync2_q <= sync1_q;
            cnt_ref <= bin_dec;
        end
    end

    always_comb begin
        bin_dec[CW-1] = sync2_q[CW-1];
        for (int i = CW - 2; i >= 0; i--) begin
            bin_dec[i] = bin_dec[i+1] ^ sync2_q[i];
        end
    end
endmodule

// File: rtl/flk_window.sv
module flk_window #(
    parameter int unsigned CW = 24,
    parameter int unsigned WW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [WW-1:0] win_len,
    input  logic [CW-1:0] cnt_in,
    output logic          done,
    output logic [CW-1:0] meas
);
    logic [WW-1:0] tick_q;
    logic [CW-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            snap_q <= '0;
            meas   <= '0;
            done   <= 1'b0;
        end else if (restart) begin
            tick_q <= '0;
            snap_q <= cnt_in;
            done   <= 1'b0;
        end else if (tick_q == win_len - 1'b1) begin
            tick_q <= '0;
            snap_q <= cnt_in;
            meas   <= cnt_in - snap_q;
            done   <= 1'b1;
        end else begin
            tick_q <= tick_q + 1'b1;
            done   <= 1'b0;
        end
    end
endmodule

// File: rtl/flk_lock_fsm.sv
module flk_lock_fsm
    import flk_pkg::*;
#(
    parameter int unsigned CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic          done,
    input  logic [CW-1:0] meas,
    input  logic [CW-1:0] exp_cnt,
    input  logic [CW-1:0] acq_tol,
    input  logic [CW-1:0] hold_tol,
    output lock_state_e   state,
    output logic          lol,
    output logic          phase_sel
);
    lock_state_e   nxt;
    logic [CW-1:0] err;

    assign err = (meas >= exp_cnt) ? (meas - exp_cnt) : (exp_cnt - meas);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_PRIME:  if (done) nxt = ST_HUNT;
            ST_HUNT:   if (done && (err <= acq_tol)) nxt = ST_LOCKED;
            ST_LOCKED: if (done && (err > hold_tol)) nxt = ST_HUNT;
            default:   nxt = ST_PRIME;
        endcase
        if (restart) nxt = (state == ST_PRIME) ? ST_PRIME : ST_HUNT;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PRIME;
        else        state <= nxt;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lol       <= 1'b1;
            phase_sel <= 1'b0;
        end else begin
            lol       <= (nxt != ST_LOCKED);
            phase_sel <= (nxt == ST_LOCKED);
        end
    end
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
    import flk_pkg::*;
#(
    parameter int unsigned WIN_BASE = 4096,
    parameter int unsigned OSC_DIV  = 16,
    parameter int unsigned CW       = 24
) (
    input  logic       clk_ref,
    input  logic       clk_osc,
    input  logic       rst_n,
    input  logic [2:0] rate_sel,
    input  logic [1:0] ref_sel,
    output logic       lol,
    output logic       phase_sel
);
    localparam int unsigned WW = $clog2(WIN_BASE * 8) + 1;

    logic [4:0]    sel_s1, sel_s2, sel_q;
    logic          restart;
    logic [WW-1:0] win_len;
    logic [CW-1:0] osc_cnt;
    logic [CW-1:0] meas_cnt;
    logic          win_done;
    logic [CW-1:0] exp_cnt, acq_tol, hold_tol;
    lock_state_e   state;

    logic [CW-1:0] exp_tab  [8];
    logic [CW-1:0] acq_tab  [8];
    logic [CW-1:0] hold_tab [8];

    for (genvar g = 0; g < 8; g++) begin : g_tab
        assign exp_tab[g]  = CW'(flk_expected(g, WIN_BASE, OSC_DIV));
        assign acq_tab[g]  = CW'(flk_expected(g, WIN_BASE, OSC_DIV) / 2000);
        assign hold_tab[g] = CW'(flk_expected(g, WIN_BASE, OSC_DIV) / 1000);
    end

    // select pins: synchronize, hold, detect change
    always_ff @(posedge clk_ref or negedge rst_n) begin
        if (!rst_n) begin
            sel_s1 <= '0;
            sel_s2 <= '0;
            sel_q  <= '0;
        end else begin
            sel_s1 <= {rate_sel, ref_sel};
            sel_s2 <= sel_s1;
            sel_q  <= sel_s2;
        end
    end

    assign restart  = (sel_s2 != sel_q);
    assign win_len  = WW'(WIN_BASE) << sel_q[1:0];
    assign exp_cnt  = exp_tab[sel_q[4:2]];
    assign acq_tol  = acq_tab[sel_q[4:2]];
    assign hold_tol = hold_tab[sel_q[4:2]];

    flk_osc_tally #(.CW(CW)) u_tally (
        .clk_osc (clk_osc),
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .cnt_ref (osc_cnt)
    );

    flk_window #(.CW(CW), .WW(WW)) u_win (
        .clk     (clk_ref),
        .rst_n   (rst_n),
        .restart (restart),
        .win_len (win_len),
        .cnt_in  (osc_cnt),
        .done    (win_done),
        .meas    (meas_cnt)
    );

    flk_lock_fsm #(.CW(CW)) u_fsm (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .restart   (restart),
        .done      (win_done),
        .meas      (meas_cnt),
        .exp_cnt   (exp_cnt),
        .acq_tol   (acq_tol),
        .hold_tol  (hold_tol),
        .state     (state),
        .lol       (lol),
        .phase_sel (phase_sel)
    );
endmodule

// File: rtl/flk_checker.sv
module flk_checker
    import flk_pkg::*;
#(
    parameter int unsigned CW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          lol,
    input logic          phase_sel,
    input logic          done,
    input logic          restart,
    input lock_state_e   state,
    input logic [CW-1:0] meas,
    input logic [CW-1:0] exp_cnt,
    input logic [CW-1:0] acq_tol,
    input logic [CW-1:0] hold_tol
);
    logic [CW-1:0] dev;
    assign dev = (meas > exp_cnt) ? (meas - exp_cnt) : (exp_cnt - meas);

    a_r1_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lol && !phase_sel));

    a_r2_complementary: assert property (@(posedge clk) disable iff (!rst_n)
        lol != phase_sel);

    a_r3_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart && state == ST_HUNT && dev <= acq_tol) |=> !lol);

    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !restart && state == ST_LOCKED && dev <= hold_tol) |=> !lol);

    a_r5_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_LOCKED && dev > hold_tol) |=> lol);

    a_r6_band_no_acquire: assert property (@(posedge clk) disable iff (!rst_n)
        (done && state == ST_HUNT && dev > acq_tol) |=> lol);

    a_r7_quiet_mid_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !restart) |=> $stable(lol));

    a_r9_restart_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> lol);
endmodule

bind freq_lock_det flk_checker #(.CW(CW)) u_chk (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .lol       (lol),
    .phase_sel (phase_sel),
    .done      (win_done),
    .restart   (restart),
    .state     (state),
    .meas      (meas_cnt),
    .exp_cnt   (exp_cnt),
    .acq_tol   (acq_tol),
    .hold_tol  (hold_tol)
);

// File: tb/sim_freq_lock_det.sv
`timescale 1ns/1ps
module sim_freq_lock_det;
    localparam int unsigned WIN_BASE = 1024;
    localparam int NWIN = 8192; // window at ref code 3

    logic       clk_ref = 1'b0;
    logic       clk_osc = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] rate_sel = 3'b000;
    logic [1:0] ref_sel  = 2'b11;
    logic       lol, phase_sel;
    real        osc_half = 2.5;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         finished = 1'b0;

    always #2.5 clk_ref = ~clk_ref;
    always #(osc_half) clk_osc = ~clk_osc;

    freq_lock_det #(.WIN_BASE(WIN_BASE), .OSC_DIV(16), .CW(24)) u0 (
        .clk_ref(clk_ref), .clk_osc(clk_osc), .rst_n(rst_n),
        .rate_sel(rate_sel), .ref_sel(ref_sel),
        .lol(lol), .phase_sel(phase_sel)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk_ref);
    endtask

    // R1 R2: reset state
    task automatic t_reset();
        wait_cyc(10);
        chk("R1 lol in reset", lol, 1'b1);
        chk("R1 phase_sel in reset", phase_sel, 1'b0);
        rst_n = 1'b1;
    endtask

    // R1 R3 R7: first window discarded, lock after the second (exact rate)
    task automatic t_first_lock();
        wait_cyc(2 * NWIN - 20);
        chk("R1 no lock from first window", lol, 1'b1);
        wait_cyc(50);
        chk("R3 lock at 0 ppm", lol, 1'b0);
        chk("R2 phase loop selected", phase_sel, 1'b1);
    endtask

    // R4: about 800 ppm fast keeps lock
    task automatic t_hold_band();
        osc_half = 2.498;
        wait_cyc(2 * NWIN + 40);
        chk("R4 hold inside band", lol, 1'b0);
    endtask

    // R5: 1200 ppm fast loses lock
    task automatic t_drop();
        osc_half = 2.497;
        wait_cyc(2 * NWIN + 40);
        chk("R5 lol beyond 0.1%", lol, 1'b1);
        chk("R2 frequency loop selected", phase_sel, 1'b0);
    endtask

    // R6: band error does not acquire
    task automatic t_no_acquire_band();
        osc_half = 2.498;
        wait_cyc(2 * NWIN + 40);
        chk("R6 no acquire inside band", lol, 1'b1);
    endtask

    // R3: 400 ppm acquires
    task automatic t_acquire_400();
        osc_half = 2.499;
        wait_cyc(2 * NWIN + 40);
        chk("R3 acquire at 400 ppm", lol, 1'b0);
    endtask

    // R8 R9: switch to wrapper rate
    task automatic t_wrapper();
        rate_sel = 3'b100;
        wait_cyc(10);
        chk("R9 select change forces lol", lol, 1'b1);
        wait_cyc(2 * NWIN);
        chk("R8 native osc rejected for wrapper code", lol, 1'b1);
        osc_half = 2.333;
        wait_cyc(2 * NWIN + 40);
        chk("R8 wrapper osc locks", lol, 1'b0);
    endtask

    // R7 R10: lower reference code, osc twice the reference
    task automatic t_ref_code();
        osc_half = 1.25;
        rate_sel = 3'b000;
        ref_sel  = 2'b10;
        wait_cyc(NWIN / 2 - 20);
        chk("R7 no lock before shorter window ends", lol, 1'b1);
        wait_cyc(50);
        chk("R10 R7 lock with fast osc after 4096 cycles", lol, 1'b0);
    endtask

    // R5: slow oscillator loses lock
    task automatic t_slow_drop();
        osc_half = 1.252;
        wait_cyc(NWIN + 40);
        chk("R5 lol when osc slow", lol, 1'b1);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_first_lock();
        t_hold_band();
        t_drop();
        t_no_acquire_band();
        t_acquire_400();
        t_wrapper();
        t_ref_code();
        t_slow_drop();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk_ref);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule